// File: doc/BRIEF.md
# Multi-channel DMA interrupt aggregator

This block gathers event pulses from up to sixteen DMA channels and turns them into one interrupt line. Every channel reports three kinds of event: half of a transfer finished, one descriptor finished, and the whole descriptor queue finished. Each kind has an enable bit and a sticky pending bit. A pulse on an enabled event latches its pending bit. The interrupt output is high while at least one pending bit is set together with its enable bit.

Software reaches the enable and pending bits through a small 32-bit register port. Each channel takes one 4-bit field in a register word. Channels 0 to 7 sit in the first enable/pending pair and channels 8 to 15 sit in the second pair. Software clears pending bits by writing ones to them. A status word shows which channels report busy. Driver code typically starts by writing zero to both enable words and all ones to both pending words, then turns on the events it wants to service.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every enable and pending bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Enable words sit at offset 0x00 (channels 0-7) and 0x04 (channels 8-15). Channel c owns bits 4*(c mod 8) to 4*(c mod 8)+3 of its word. Field bit 0 is half-done, bit 1 is descriptor-done and bit 2 is queue-done. A write stores the word and a read returns it.
- R3: Field bit 3, and every field of a channel at or above NUM_CH, always reads 0 in both the enable words and the pending words.
- R4: A pending bit becomes 1 on the clock edge where its event input is 1 and its enable bit is 1. An event whose enable bit is 0 leaves the pending bit at 0.
- R5: Pending words sit at offset 0x10 (channels 0-7) and 0x14 (channels 8-15), with the R2 layout. Writing a 1 clears that pending bit and writing a 0 leaves it unchanged.
- R6: When an event sets a pending bit on the same edge that a write clears it, the bit ends up 1.
- R7: `irq` is 1 exactly when some pending bit and its enable bit are both 1. It follows the register state in the cycle after the edge that changed it.
- R8: Clearing an enable bit keeps its pending bit, but the bit no longer drives `irq`. Setting the enable bit again brings `irq` back.
- R9: The status word at offset 0x30 carries `ch_busy[c]` in bit c. All of its other bits read 0.
- R10: Read data appears on `bus_rdata` the cycle after a read request and holds until the next read. Unmapped offsets read 0. Writes to 0x30 or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_half | input | NUM_CH | Half-done event pulse, one per channel |
| ev_desc | input | NUM_CH | Descriptor-done event pulse, one per channel |
| ev_queue | input | NUM_CH | Queue-done event pulse, one per channel |
| ch_busy | input | NUM_CH | Per-channel busy level |
| irq | output | 1 | Combined interrupt request |

## Verification
Event pulses and register writes take effect on one clock edge. The pending state and `irq` are therefore due at the first falling edge after that edge. Read data is registered, so it is due at the falling edge after the edge that accepts the read request. The bench drives every input on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check lands one cycle after its stimulus. The sweeps cover every channel and event kind, and the expected word is computed as a single bit at position 4*(c mod 8)+kind in the word chosen by c/8.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int MAX_CH      = 16;
  localparam int BANK_CH     = 8;
  localparam int WORD_W      = 32;
  localparam int FIELD_W     = 4;

  localparam logic [7:0] OFF_EN_LO  = 8'h00;
  localparam logic [7:0] OFF_EN_HI  = 8'h04;
  localparam logic [7:0] OFF_PD_LO  = 8'h10;
  localparam logic [7:0] OFF_PD_HI  = 8'h14;
  localparam logic [7:0] OFF_STATUS = 8'h30;

  typedef enum logic [1:0] {
    EV_HALF  = 2'd0,
    EV_DESC  = 2'd1,
    EV_QUEUE = 2'd2
  } ev_kind_e;

  typedef struct packed {
    logic en_lo;
    logic en_hi;
    logic pd_lo;
    logic pd_hi;
    logic status;
  } reg_sel_t;

  // bit position of an event kind for a channel inside its bank word
  function automatic int field_bit(input int ch_in_bank, input ev_kind_e kind);
    return ch_in_bank * FIELD_W + int'(kind);
  endfunction

  // bits that can hold state in a bank with live_ch channels present
  function automatic logic [WORD_W-1:0] live_mask(input int live_ch);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int c = 0; c < BANK_CH; c++) begin
      if (c < live_ch) begin
        m[field_bit(c, EV_HALF)]  = 1'b1;
        m[field_bit(c, EV_DESC)]  = 1'b1;
        m[field_bit(c, EV_QUEUE)] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic int bank_live(input int num_ch, input int bank);
    int rest;
    rest = num_ch - bank * BANK_CH;
    if (rest < 0) return 0;
    if (rest > BANK_CH) return BANK_CH;
    return rest;
  endfunction

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_t          wr_sel,
  output reg_sel_t          rd_sel,
  output logic              rd_req
);

  reg_sel_t hit;

  always_comb begin
    hit        = '0;
    hit.en_lo  = (bus_addr == ADDR_W'(OFF_EN_LO));
    hit.en_hi  = (bus_addr == ADDR_W'(OFF_EN_HI));
    hit.pd_lo  = (bus_addr == ADDR_W'(OFF_PD_LO));
    hit.pd_hi  = (bus_addr == ADDR_W'(OFF_PD_HI));
    hit.status = (bus_addr == ADDR_W'(OFF_STATUS));
  end

  assign rd_req = bus_sel && !bus_wr;

  always_comb begin
    wr_sel        = (bus_sel && bus_wr) ? hit : '0;
    // status is read-only; a write there selects nothing
    wr_sel.status = 1'b0;
    rd_sel        = rd_req ? hit : '0;
  end

endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int LIVE_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              pd_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BANK_CH-1:0] ev_half,
  input  logic [BANK_CH-1:0] ev_desc,
  input  logic [BANK_CH-1:0] ev_queue,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] pend_q,
  output logic              irq_part
);

  localparam logic [WORD_W-1:0] LIVE_MASK = live_mask(LIVE_CH);

  logic [WORD_W-1:0] evt_vec;
  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] clr_vec;

  for (genvar c = 0; c < BANK_CH; c++) begin : g_field
    assign evt_vec[c*FIELD_W + 0] = ev_half[c];
    assign evt_vec[c*FIELD_W + 1] = ev_desc[c];
    assign evt_vec[c*FIELD_W + 2] = ev_queue[c];
    assign evt_vec[c*FIELD_W + 3] = 1'b0;
  end

  assign set_vec = evt_vec & en_q & LIVE_MASK;
  assign clr_vec = pd_wr ? (wdata & LIVE_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_wr) begin
      en_q <= wdata & LIVE_MASK;
    end
  end

  // set beats clear when both land on one bit in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end

  assign irq_part = |(pend_q & en_q);

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q | pend_q) & ~LIVE_MASK) == '0); // R3

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~($past(evt_vec) & $past(en_q))) == '0)); // R4

  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~pend_q) & ~($past(wdata) & {WORD_W{$past(pd_wr)}})) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_vec) & $past(en_q) & LIVE_MASK & ~pend_q) == '0)); // R6

  AST_EN_WRITE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !pd_wr) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R8

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] ev_half,
  input  logic [NUM_CH-1:0] ev_desc,
  input  logic [NUM_CH-1:0] ev_queue,
  input  logic [NUM_CH-1:0] ch_busy,
  output logic              irq
);

  localparam int LIVE_LO = bank_live(NUM_CH, 0);
  localparam int LIVE_HI = bank_live(NUM_CH, 1);

  reg_sel_t wr_sel;
  reg_sel_t rd_sel;
  logic     rd_req;

  logic [MAX_CH-1:0] half_all, desc_all, queue_all;
  logic [WORD_W-1:0] status_word;
  logic [WORD_W-1:0] en_lo, en_hi, pd_lo, pd_hi;
  logic              irq_lo, irq_hi;
  logic [WORD_W-1:0] rd_word;

  for (genvar i = 0; i < WORD_W; i++) begin : g_pad
    if (i < NUM_CH) begin : g_live
      assign status_word[i] = ch_busy[i];
    end else begin : g_dead
      assign status_word[i] = 1'b0;
    end
    if (i < MAX_CH) begin : g_ev
      if (i < NUM_CH) begin : g_on
        assign half_all[i]  = ev_half[i];
        assign desc_all[i]  = ev_desc[i];
        assign queue_all[i] = ev_queue[i];
      end else begin : g_off
        assign half_all[i]  = 1'b0;
        assign desc_all[i]  = 1'b0;
        assign queue_all[i] = 1'b0;
      end
    end
  end

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_sel  (wr_sel),
    .rd_sel  (rd_sel),
    .rd_req  (rd_req)
  );

  dma_irq_bank #(.LIVE_CH(LIVE_LO)) u_bank_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_wr   (wr_sel.en_lo),
    .pd_wr   (wr_sel.pd_lo),
    .wdata   (bus_wdata),
    .ev_half (half_all[BANK_CH-1:0]),
    .ev_desc (desc_all[BANK_CH-1:0]),
    .ev_queue(queue_all[BANK_CH-1:0]),
    .en_q    (en_lo),
    .pend_q  (pd_lo),
    .irq_part(irq_lo)
  );

  dma_irq_bank #(.LIVE_CH(LIVE_HI)) u_bank_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_wr   (wr_sel.en_hi),
    .pd_wr   (wr_sel.pd_hi),
    .wdata   (bus_wdata),
    .ev_half (half_all[MAX_CH-1:BANK_CH]),
    .ev_desc (desc_all[MAX_CH-1:BANK_CH]),
    .ev_queue(queue_all[MAX_CH-1:BANK_CH]),
    .en_q    (en_hi),
    .pend_q  (pd_hi),
    .irq_part(irq_hi)
  );

  always_comb begin
    rd_word = '0;
    if (rd_sel.en_lo)  rd_word = en_lo;
    if (rd_sel.en_hi)  rd_word = en_hi;
    if (rd_sel.pd_lo)  rd_word = pd_lo;
    if (rd_sel.pd_hi)  rd_word = pd_hi;
    if (rd_sel.status) rd_word = status_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      bus_rdata <= rd_word;
    end
  end

  assign irq = irq_lo | irq_hi;

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|{ev_half, ev_desc, ev_queue}) || (bus_sel && bus_wr))); // R7

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R10

endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;

  localparam int NUM_CH = 16;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CH-1:0] ev_half = '0;
  logic [NUM_CH-1:0] ev_desc = '0;
  logic [NUM_CH-1:0] ev_queue = '0;
  logic [NUM_CH-1:0] ch_busy = '0;
  logic              irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_irq_agg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_half(ev_half), .ev_desc(ev_desc), .ev_queue(ev_queue),
    .ch_busy(ch_busy), .irq(irq)
  );

  localparam logic [31:0] FIELD_LIVE = 32'h7777_7777;

  function automatic logic [7:0] en_addr(input int ch);
    return (ch < 8) ? 8'h00 : 8'h04;
  endfunction
  function automatic logic [7:0] pd_addr(input int ch);
    return (ch < 8) ? 8'h10 : 8'h14;
  endfunction
  function automatic logic [31:0] one_bit(input int ch, input int kind);
    return 32'd1 << ((ch % 8) * 4 + kind);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int ch, input int kind);
    @(negedge clk);
    if (kind == 0) ev_half[ch] = 1'b1;
    if (kind == 1) ev_desc[ch] = 1'b1;
    if (kind == 2) ev_queue[ch] = 1'b1;
    @(negedge clk);
    ev_half = '0; ev_desc = '0; ev_queue = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(8'h00, v); chk("R1 en_lo", v, 32'd0);
    rd(8'h04, v); chk("R1 en_hi", v, 32'd0);
    rd(8'h10, v); chk("R1 pd_lo", v, 32'd0);
    rd(8'h14, v); chk("R1 pd_hi", v, 32'd0);

    // R2 / R3 enable store with spare bits masked
    wr(8'h00, 32'h1234_5678); rd(8'h00, v); chk("R2 en_lo pattern", v, 32'h1234_5678 & FIELD_LIVE);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R3 en_hi spare", v, FIELD_LIVE);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R3 en_lo spare", v, FIELD_LIVE);

    // R4 R5 R7 sweep over every channel and kind, all enabled
    for (int c = 0; c < NUM_CH; c++) begin
      for (int k = 0; k < 3; k++) begin
        pulse(c, k);
        chk("R7 irq after event", {31'd0, irq}, 32'd1);
        rd(pd_addr(c), v); chk("R4 pending set", v, one_bit(c, k));
        rd(pd_addr(c) ^ 8'h04, v); chk("R4 other word", v, 32'd0);
        wr(pd_addr(c), ~one_bit(c, k)); rd(pd_addr(c), v);
        chk("R5 write zero keeps", v, one_bit(c, k));
        wr(pd_addr(c), one_bit(c, k)); rd(pd_addr(c), v);
        chk("R5 write one clears", v, 32'd0);
        chk("R7 irq after clear", {31'd0, irq}, 32'd0);
      end
    end

    // R4 disabled events ignored
    wr(8'h00, 32'd0); wr(8'h04, 32'd0);
    for (int c = 0; c < NUM_CH; c++) begin
      for (int k = 0; k < 3; k++) begin
        pulse(c, k);
        rd(pd_addr(c), v); chk("R4 disabled ignored", v, 32'd0);
      end
    end
    chk("R4 irq stays low", {31'd0, irq}, 32'd0);

    // R4 single enable bit: only that kind latches
    wr(8'h04, one_bit(11, 1));
    pulse(11, 0); pulse(11, 1); pulse(11, 2);
    rd(8'h14, v); chk("R4 selective", v, one_bit(11, 1));

    // R8 enable off keeps pending, drops irq
    chk("R8 irq before", {31'd0, irq}, 32'd1);
    wr(8'h04, 32'd0);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    rd(8'h14, v); chk("R8 pending kept", v, one_bit(11, 1));
    wr(8'h04, one_bit(11, 1));
    chk("R8 irq back", {31'd0, irq}, 32'd1);
    wr(8'h14, 32'hFFFF_FFFF);
    chk("R5 all ones clears", {31'd0, irq}, 32'd0);

    // R6 set and clear in the same cycle
    wr(8'h00, FIELD_LIVE);
    pulse(3, 2);
    @(negedge clk);
    ev_queue[3] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    ev_queue = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h10, v); chk("R6 set wins", v, one_bit(3, 2));
    wr(8'h10, 32'hFFFF_FFFF);

    // R9 status reflects busy
    for (int p = 0; p < 4; p++) begin
      logic [NUM_CH-1:0] pat;
      pat = NUM_CH'(32'h0001_A5C3 * (p + 1) + p);
      @(negedge clk); ch_busy = pat;
      rd(8'h30, v); chk("R9 status", v, {{(32-NUM_CH){1'b0}}, pat});
    end

    // R10 unmapped read, ignored writes, hold
    rd(8'h08, v); chk("R10 unmapped read", v, 32'd0);
    rd(8'h30, v);
    wr(8'h30, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R10 rdata holds", bus_rdata, {{(32-NUM_CH){1'b0}}, ch_busy});
    rd(8'h00, v); chk("R10 write elsewhere ignored en", v, FIELD_LIVE);
    rd(8'h10, v); chk("R10 write elsewhere ignored pd", v, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule